// File: doc/BRIEF.md
# Burst Column Address Sequencer

This block produces the column address for each beat of one memory burst. A one-cycle start pulse captures a starting column, a burst-length code and an ordering bit. From the next cycle on, the block presents one column per clock with a valid flag. A last flag marks the final beat of a fixed-length burst.

Fixed bursts of 1, 2, 4 or 8 beats stay inside the aligned block of that size that holds the start column. The columns inside that block are visited in one of two orders. In sequential order the offset counts up and wraps. In interleaved order the offset is the start offset XOR the beat number. A full-row burst counts up through every column of the row, modulo the row size, and runs until it is stopped. A stop pulse ends any burst at once. A new start pulse cuts off a running burst and begins the new one.

Top module: `burst_addr_gen`

## Requirements
- R1: While reset is held and after it is released, with no start pulse, `beat_valid` and `beat_last` are 0 and `col_out` is 0. `col_out` is 0 whenever `beat_valid` is 0.
- R2: A `burst_start` pulse sampled at a clock edge makes `beat_valid` 1 in the following cycle, with `col_out` equal to the captured `start_col`.
- R3: `len_code` 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Codes 4, 5 and 6 give a single beat. Code 7 selects a full-row burst. With no stop or start pulse, a fixed burst is valid for exactly that many consecutive cycles.
- R4: With `order_sel` = 0 and a fixed length N, beat k presents the start column with its low log2(N) bits replaced by (start + k) mod N. The upper bits stay fixed.
- R5: With `order_sel` = 1 and a fixed length of 2, 4 or 8, beat k presents the start column with its low log2(N) bits replaced by (start XOR k).
- R6: A full-row burst increments the column by 1 modulo 256 on every beat, whatever the value of `order_sel`. It repeats the start column after 256 beats and runs until a stop or start pulse.
- R7: `beat_last` is 1 only on the final beat of a fixed-length burst. It is never 1 during a full-row burst.
- R8: A `burst_stop` pulse sampled while a burst runs makes the beat shown in that cycle the final one, so `beat_valid` is 0 in the next cycle. A stop pulse while idle has no effect. If start and stop come in the same cycle, the start wins.
- R9: A start pulse during a running burst abandons that burst. The next cycle shows beat 0 of the new burst at the new start column.
- R10: `start_col`, `len_code` and `order_sel` are sampled only with a start pulse. Changing them during a burst does not alter the running sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| burst_start | input | 1 | One-cycle pulse that begins a burst |
| start_col | input | 8 | Starting column, captured with the start pulse |
| len_code | input | 3 | Burst-length code (0:1, 1:2, 2:4, 3:8, 4-6:1, 7:full row) |
| order_sel | input | 1 | 0 sequential, 1 interleaved |
| burst_stop | input | 1 | One-cycle pulse that ends the running burst |
| col_out | output | 8 | Column address of the current beat |
| beat_valid | output | 1 | Current cycle carries a beat |
| beat_last | output | 1 | Current beat is the final beat of a fixed burst |

## Verification
The assertions assume that the burst settings are meaningful only in the cycle of a start pulse. The checker therefore captures its own copy of the length code at each start and judges later beats against that copy, not against the live inputs. The assertions accept any mix of start and stop pulses, including both in the same cycle. The stimulus changes the settings on every cycle, fires start pulses while bursts are running, and fires stop pulses while idle, so the assertions are tested against inputs that vary freely outside the start cycle.

// File: rtl/bag_pkg.sv
// Package: shared types for the burst column sequencer.
// Assumes length codes are 3 bits wide, with code 7 meaning a full-row burst.
package bag_pkg;

    localparam int LEN_CODE_W = 3;
    localparam logic [LEN_CODE_W-1:0] LEN_FULL_ROW = 3'd7;

    typedef enum logic {
        ORD_SEQ   = 1'b0,
        ORD_XOR   = 1'b1
    } order_e;

    // Decoded shape of a burst: window width and ordering.
    typedef struct packed {
        logic       full;     // full-row burst, runs until stopped
        logic       xor_ord;  // interleaved ordering in the window
        logic [1:0] lg;       // log2 of the fixed burst length
    } shape_t;

endpackage

// File: rtl/bag_len_decode.sv
// Module: turns the length code and ordering bit into a burst shape.
// Assumes the reserved codes 4..6 mean one beat, and interleaving is
// meaningful only for fixed lengths of 2 or more.
module bag_len_decode
    import bag_pkg::*;
(
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  order_sel,
    output shape_t                shape
);

    // Decode the code into window width, full-row flag and ordering.
    always_comb begin
        shape.full = (len_code == LEN_FULL_ROW);
        shape.lg   = (len_code <= 3'd3) ? len_code[1:0] : 2'd0;
        shape.xor_ord = (order_e'(order_sel) == ORD_XOR) && !shape.full
                        && (shape.lg != 2'd0);
    end

endmodule

// File: rtl/bag_beat_ctrl.sv
// Module: tracks whether a burst runs, and which beat it is on.
// Assumes shape is the captured burst shape, stable during a burst.
// A start outranks a stop. A full-row burst ends only on a stop or a new start.
module bag_beat_ctrl
    import bag_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             stop,
    input  shape_t           shape,
    output logic             active,
    output logic [CNT_W-1:0] beat,
    output logic             last
);

    logic [CNT_W-1:0] final_beat;

    // Index of the final beat of a fixed-length burst.
    always_comb final_beat = (CNT_W'(1) << shape.lg) - CNT_W'(1);

    // Flag the final beat of a running fixed-length burst.
    always_comb last = active && !shape.full && (beat == final_beat);

    // Advance the beat counter and end or restart the burst.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active <= 1'b0;
            beat   <= '0;
        end else if (start) begin
            active <= 1'b1;
            beat   <= '0;
        end else if (stop) begin
            active <= 1'b0;
        end else if (active) begin
            if (last) begin
                active <= 1'b0;
            end else begin
                beat <= beat + CNT_W'(1);
            end
        end
    end

endmodule

// File: rtl/bag_col_calc.sv
// Module: forms the column of beat k from the start column and the shape.
// Assumes beat is smaller than the window size for fixed bursts.
// Bits outside the window pass through from the start column.
module bag_col_calc
    import bag_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic [COL_W-1:0] base,
    input  logic [COL_W-1:0] beat,
    input  shape_t           shape,
    output logic [COL_W-1:0] col
);

    logic [COL_W-1:0] seq_col;
    logic [COL_W-1:0] xor_col;

    // Candidate columns for the two orderings.
    always_comb begin
        seq_col = base + beat;
        xor_col = base ^ beat;
    end

    // Per-bit choice: inside the window take the ordered bit, else the base bit.
    for (genvar i = 0; i < COL_W; i++) begin : g_bit
        logic in_win;
        always_comb begin
            in_win = shape.full || (int'(shape.lg) > i);
            col[i] = in_win ? (shape.xor_ord ? xor_col[i] : seq_col[i]) : base[i];
        end
    end

endmodule

// File: rtl/burst_addr_gen.sv
// Module: top of the burst column sequencer.
// Captures the burst settings on a start pulse and then presents one column
// per clock. Assumes the settings are meaningful only in the start cycle.
module burst_addr_gen
    import bag_pkg::*;
#(
    parameter int COL_W = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  burst_start,
    input  logic [COL_W-1:0]      start_col,
    input  logic [LEN_CODE_W-1:0] len_code,
    input  logic                  order_sel,
    input  logic                  burst_stop,
    output logic [COL_W-1:0]      col_out,
    output logic                  beat_valid,
    output logic                  beat_last
);

    shape_t           shape_in;
    shape_t           shape_q;
    logic [COL_W-1:0] base_q;
    logic [COL_W-1:0] beat;
    logic [COL_W-1:0] col_calc;
    logic             active;

    bag_len_decode u_dec (
        .len_code  (len_code),
        .order_sel (order_sel),
        .shape     (shape_in)
    );

    // Capture the start column and the decoded shape with each start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q  <= '0;
            shape_q <= '0;
        end else if (burst_start) begin
            base_q  <= start_col;
            shape_q <= shape_in;
        end
    end

    bag_beat_ctrl #(.CNT_W(COL_W)) u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (burst_start),
        .stop   (burst_stop),
        .shape  (shape_q),
        .active (active),
        .beat   (beat),
        .last   (beat_last)
    );

    bag_col_calc #(.COL_W(COL_W)) u_col (
        .base  (base_q),
        .beat  (beat),
        .shape (shape_q),
        .col   (col_calc)
    );

    // Drive the outputs, holding the column at zero while idle.
    always_comb begin
        beat_valid = active;
        col_out    = active ? col_calc : '0;
    end

endmodule

// File: rtl/bag_chk.sv
// Checker: temporal properties of the burst column sequencer, bound to the top.
// Keeps its own copy of the length code captured at each start pulse.
module bag_chk #(
    parameter int COL_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             burst_start,
    input logic [COL_W-1:0] start_col,
    input logic [2:0]       len_code,
    input logic             burst_stop,
    input logic [COL_W-1:0] col_out,
    input logic             beat_valid,
    input logic             beat_last
);

    logic             c_full;
    logic [COL_W-1:0] c_mask;

    // Capture the burst shape seen by the checker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_full <= 1'b0;
            c_mask <= '0;
        end else if (burst_start) begin
            c_full <= (len_code == 3'd7);
            c_mask <= (len_code == 3'd7) ? '1 :
                      (len_code <= 3'd3) ? ((COL_W'(1) << len_code) - COL_W'(1)) : '0;
        end
    end

    AST_IDLE_COL_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !beat_valid |-> (col_out == '0) && !beat_last);                         // R1
    AST_START_FIRST_BEAT: assert property (@(posedge clk) disable iff (!rst_n)
        burst_start |=> beat_valid && (col_out == $past(start_col)));           // R2
    AST_UPPER_BITS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && $past(beat_valid) && !$past(burst_start)
        |-> ((col_out & ~c_mask) == ($past(col_out) & ~c_mask)));               // R4
    AST_FULL_ROW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && $past(beat_valid) && !$past(burst_start) && c_full
        |-> (col_out == $past(col_out) + COL_W'(1)));                           // R6
    AST_NO_LAST_FULL_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        beat_valid && c_full |-> !beat_last);                                   // R7
    AST_LAST_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        beat_last && !burst_start |=> !beat_valid);                             // R7
    AST_STOP_ENDS_BURST: assert property (@(posedge clk) disable iff (!rst_n)
        burst_stop && !burst_start |=> !beat_valid);                            // R8

endmodule

bind burst_addr_gen bag_chk #(.COL_W(COL_W)) u_bag_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .burst_start (burst_start),
    .start_col   (start_col),
    .len_code    (len_code),
    .burst_stop  (burst_stop),
    .col_out     (col_out),
    .beat_valid  (beat_valid),
    .beat_last   (beat_last)
);

// File: tb/sim_burst_addr_gen.sv
`timescale 1ns/1ps
module sim_burst_addr_gen;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       burst_start = 1'b0;
    logic [7:0] start_col = '0;
    logic [2:0] len_code = '0;
    logic       order_sel = 1'b0;
    logic       burst_stop = 1'b0;
    logic [7:0] col_out;
    logic       beat_valid;
    logic       beat_last;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2.5 clk = ~clk;

    burst_addr_gen u0 (
        .clk(clk), .rst_n(rst_n), .burst_start(burst_start), .start_col(start_col),
        .len_code(len_code), .order_sel(order_sel), .burst_stop(burst_stop),
        .col_out(col_out), .beat_valid(beat_valid), .beat_last(beat_last)
    );

    // Burst length from the code; 0 stands for a full-row burst.
    function automatic int ref_len(input logic [2:0] code);
        if (code == 3'd7) return 0;
        if (code <= 3'd3) return 1 << code;
        return 1;
    endfunction

    // Expected column of beat k, from the ordering rules.
    function automatic logic [7:0] ref_col(input logic [7:0] s, input logic [2:0] code,
                                           input logic typ, input int k);
        int n = ref_len(code);
        int off;
        int blk;
        if (n == 0) return 8'((int'(s) + k) % 256);
        blk = int'(s) - (int'(s) % n);
        off = typ ? ((int'(s) % n) ^ k) : (((int'(s) % n) + k) % n);
        return 8'(blk + off);
    endfunction

    // Reference state, updated on the same edges as the design.
    logic       m_act = 1'b0;
    int         m_k = 0;
    logic [7:0] m_s = '0;
    logic [2:0] m_code = '0;
    logic       m_typ = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_act <= 1'b0;
            m_k   <= 0;
        end else if (burst_start) begin
            m_act <= 1'b1; m_k <= 0;
            m_s <= start_col; m_code <= len_code; m_typ <= order_sel;
        end else if (burst_stop) begin
            m_act <= 1'b0;
        end else if (m_act) begin
            if (ref_len(m_code) != 0 && m_k == ref_len(m_code) - 1) m_act <= 1'b0;
            else m_k <= m_k + 1;
        end
    end

    task automatic check(input string tag, input bit ok, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
        end
    endtask

    // Wait one clock, then compare all outputs with the reference.
    task automatic tick(input string tag);
        logic [7:0] ec;
        logic       el;
        @(posedge clk); #1;
        ec = m_act ? ref_col(m_s, m_code, m_typ, m_k) : 8'h00;
        el = m_act && ref_len(m_code) != 0 && m_k == ref_len(m_code) - 1;
        check(tag, {beat_valid, beat_last, col_out} == {m_act, el, ec},
              {6'b0, beat_valid, beat_last, col_out}, {6'b0, m_act, el, ec});
    endtask

    task automatic expect_beat(input string tag, input logic [7:0] col, input logic lst);
        check(tag, beat_valid && col_out == col && beat_last == lst,
              {6'b0, beat_valid, beat_last, col_out}, {6'b0, 1'b1, lst, col});
    endtask

    task automatic launch(input logic [7:0] s, input logic [2:0] code, input logic typ);
        burst_start = 1'b1; start_col = s; len_code = code; order_sel = typ;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) tick("R1");
        @(posedge clk); #1; rst_n = 1'b1;
        tick("R1");

        // R4: sequential length 4 from 0x0E wraps in its block
        launch(8'h0E, 3'd2, 1'b0);
        tick("R2"); burst_start = 1'b0; expect_beat("R2", 8'h0E, 1'b0);
        len_code = 3'd7; order_sel = 1'b1; start_col = 8'hAA; // R10: ignored mid-burst
        tick("R4"); expect_beat("R4", 8'h0F, 1'b0);
        tick("R4"); expect_beat("R10", 8'h0C, 1'b0);
        tick("R4"); expect_beat("R7", 8'h0D, 1'b1);
        tick("R3");

        // R5: interleaved length 8 from 0x35
        launch(8'h35, 3'd3, 1'b1);
        begin
            logic [7:0] xs [8] = '{8'h35, 8'h34, 8'h37, 8'h36, 8'h31, 8'h30, 8'h33, 8'h32};
            for (int k = 0; k < 8; k++) begin
                tick("R5"); burst_start = 1'b0;
                expect_beat("R5", xs[k], k == 7);
            end
        end
        tick("R3");

        // R3: reserved code gives one beat
        launch(8'h77, 3'd5, 1'b1);
        tick("R3"); burst_start = 1'b0; expect_beat("R3", 8'h77, 1'b1);
        tick("R3");

        // R6: full row from 0xFE wraps and ignores interleave; runs 256+ beats
        launch(8'hFE, 3'd7, 1'b1);
        tick("R6"); burst_start = 1'b0; expect_beat("R6", 8'hFE, 1'b0);
        tick("R6"); expect_beat("R6", 8'hFF, 1'b0);
        tick("R6"); expect_beat("R6", 8'h00, 1'b0);
        for (int k = 3; k < 256; k++) tick("R6");
        tick("R6"); expect_beat("R6", 8'hFE, 1'b0);
        burst_stop = 1'b1;  // R8: stop ends full row
        tick("R8"); burst_stop = 1'b0;
        check("R8", !beat_valid, {15'b0, beat_valid}, 16'h0);
        // R8: stop while idle has no effect
        burst_stop = 1'b1; tick("R8"); burst_stop = 1'b0; tick("R8");
        check("R8", !beat_valid && col_out == 8'h00, {7'b0, beat_valid, col_out}, 16'h0);

        // R9: restart mid-burst, together with a stop (start wins)
        launch(8'h10, 3'd3, 1'b0);
        tick("R9"); burst_start = 1'b0; tick("R9");
        launch(8'h41, 3'd1, 1'b1); burst_stop = 1'b1;
        tick("R9"); burst_start = 1'b0; burst_stop = 1'b0;
        expect_beat("R9", 8'h41, 1'b0);
        tick("R5"); expect_beat("R5", 8'h40, 1'b1);
        tick("R3");

        // Random mix against the reference model
        for (int i = 0; i < 4000; i++) begin
            start_col = 8'($urandom);
            len_code  = 3'($urandom);
            order_sel = 1'($urandom);
            burst_start = beat_valid ? ($urandom_range(0, 19) == 0) : ($urandom_range(0, 2) == 0);
            burst_stop  = ($urandom_range(0, 14) == 0);
            tick("R4_R5_R8_R9_R10");
        end
        burst_start = 1'b0; burst_stop = 1'b0;
        repeat (4) tick("R3");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule